// File: doc/BRIEF.md
# Serial Register-Access Slave

A host reaches a bank of 8-bit configuration registers through this block, using four serial wires. Those wires are a chip select (active low), a serial clock, a serial data input and a serial data output with its own output-enable. The block samples all serial pins with the system clock, so the host's serial clock must be much slower than the system clock. Every access is one frame of sixteen serial clocks. The first eight bits form a command: one direction flag, five address bits and two bits that are ignored. The last eight bits carry the data.

All bits travel least-significant first. A write frame leaves the output disabled and stores the data byte only once its last bit has arrived. A read frame enables the output for the data byte and shifts the addressed register out on falling serial clock edges, so each bit is stable before the host's next rising edge. Raising chip select ends a frame at any bit and leaves the registers as they were. A second, parallel read port lets a test environment look at any register directly.

The serial clock must stay high for at least four system clocks and low for at least four system clocks. Chip select must stay high for at least four system clocks between frames.

Top module: `ser_reg_slave`

## Requirements
- R1: A complete write frame stores the eight data bits in the addressed register. Data bits sit at frame positions 8..15, with the first of them the register's bit 0.
- R2: Frame bit 0 selects the direction: 1 is a read, 0 is a write.
- R3: Frame bits 1..5 form the register address, the first of them the address LSB. All 32 addresses from 0 to 31 are reachable.
- R4: Frame bits 6 and 7 have no effect on which register is accessed.
- R5: In a read frame, the addressed register is driven on `sdo` with `sdo_oe` high, bit 0 first. Each bit is updated after a falling serial clock edge and holds until the next one. Bit 0 is valid before the first rising edge of the data byte.
- R6: During the data byte of a read frame, `sdi` is ignored and no register changes.
- R7: `sdo_oe` stays low throughout the command byte of every frame and throughout every write frame.
- R8: Chip select going high at any bit ends the frame: `sdo_oe` drops within three system clocks, and the next frame starts again from bit 0.
- R9: A write frame cut short before its sixteenth bit leaves every register unchanged.
- R10: After reset, every register reads zero and `sdo_oe` is low.
- R11: `tap_data` shows the register selected by `tap_addr` by the second rising system clock edge after `tap_addr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| tap_addr | input | 5 | Parallel test read address |
| tap_data | output | 8 | Parallel test read data |

## Verification
A wrong bit count or a wrong direction flag inside the block shows up on the pins straight away. `sdo_oe` rises during a command byte or a write frame, or fails to rise before the first data-phase rising edge, and the per-clock enable comparison catches this within the same serial bit. Address or data shifted in the wrong order does not show in the frame where it happens. It shows at the next read-back through `tap_data` or `sdo`, a few system clocks after the frame closes. An early write commit is caught as soon as a frame cut short is read back.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  localparam logic DIR_READ = 1'b1;
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic sdi_s
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      cs_idle <= 1'b1;
      sdi_s   <= 1'b0;
    end else begin
      s1      <= sclk;
      s2      <= s1;
      cs_idle <= cs_n;
      sdi_s   <= sdi;
    end
  end

  assign sclk_rise = s1 & ~s2;
  assign sclk_fall = ~s1 & s2;
endmodule

// File: rtl/ser_frame_ctl.sv
module ser_frame_ctl
  import ser_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int SKIP_W = 2,
  localparam int CMD_W      = 1 + ADDR_W + SKIP_W,
  localparam int FRAME_BITS = CMD_W + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1),
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_idle,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              rw
);
  phase_e           ph;
  logic [IDX_W-1:0] didx;

  always_comb begin
    if (bit_cnt < CNT_W'(CMD_W))           ph = PH_CMD;
    else if (bit_cnt < CNT_W'(FRAME_BITS)) ph = PH_DATA;
    else                                   ph = PH_DONE;
  end

  assign didx = IDX_W'(bit_cnt - CNT_W'(CMD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      wr_data <= '0;
    end else if (!cs_idle && sclk_rise && ph != PH_DONE) begin
      if (bit_cnt != '0 && bit_cnt <= CNT_W'(ADDR_W))
        addr <= {sdi_s, addr[ADDR_W-1:1]};
      if (ph == PH_DATA)
        wr_data <= {sdi_s, wr_data[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      bit_cnt <= '0;
      rw      <= 1'b0;
      wr_en   <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (sclk_rise && ph != PH_DONE) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == '0)
          rw <= sdi_s;
        if (bit_cnt == CNT_W'(FRAME_BITS - 1) && rw != DIR_READ)
          wr_en <= 1'b1;
      end
      if (sclk_fall) begin
        if (rw == DIR_READ && ph == PH_DATA) begin
          sdo    <= rd_word[didx];
          sdo_oe <= 1'b1;
        end else begin
          sdo    <= 1'b0;
          sdo_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [DATA_W-1:0] ra_q, rb_q;
  logic              ra_v, rb_v;

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
    ra_q <= mem[ra_addr];
    rb_q <= mem[rb_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      ra_v    <= 1'b0;
      rb_v    <= 1'b0;
    end else begin
      if (wr_en)
        written[wr_addr] <= 1'b1;
      ra_v <= written[ra_addr];
      rb_v <= written[rb_addr];
    end
  end

  assign ra_data = ra_v ? ra_q : '0;
  assign rb_data = rb_v ? rb_q : '0;
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int SKIP_W = 2,
  localparam int CMD_W      = 1 + ADDR_W + SKIP_W,
  localparam int FRAME_BITS = CMD_W + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [ADDR_W-1:0] tap_addr,
  output logic [DATA_W-1:0] tap_data
);
  logic              sclk_rise, sclk_fall, cs_idle, sdi_s;
  logic [ADDR_W-1:0] addr;
  logic              wr_en, rw;
  logic [DATA_W-1:0] wr_data, rd_word;
  logic [CNT_W-1:0]  bit_cnt;

  ser_edge_sync u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .sdi_s(sdi_s)
  );

  ser_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SKIP_W(SKIP_W)) u_ctl (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .sdi_s(sdi_s), .rd_word(rd_word),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .bit_cnt(bit_cnt), .rw(rw)
  );

  ser_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .ra_addr(addr), .ra_data(rd_word),
    .rb_addr(tap_addr), .rb_data(tap_data)
  );
endmodule

// File: rtl/ser_reg_slave_chk.sv
module ser_reg_slave_chk #(
  parameter int CNT_W      = 5,
  parameter int CMD_W      = 8,
  parameter int FRAME_BITS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_idle,
  input logic             sclk_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rw,
  input logic             wr_en,
  input logic             sdo,
  input logic             sdo_oe
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_BITS)); // R1

  AST_WRITE_AT_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (bit_cnt == CNT_W'(FRAME_BITS) && !rw)); // R9

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> rw); // R7

  AST_OE_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (bit_cnt >= CNT_W'(CMD_W))); // R7

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (bit_cnt == '0 && !sdo_oe && !wr_en)); // R8

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cs_idle && !sclk_fall) |=> ($stable(sdo) && $stable(sdo_oe))); // R5
endmodule

bind ser_reg_slave ser_reg_slave_chk #(
  .CNT_W(CNT_W), .CMD_W(CMD_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_idle), .sclk_fall(sclk_fall),
  .bit_cnt(bit_cnt), .rw(rw), .wr_en(wr_en), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/test_ser_reg_slave.sv
module test_ser_reg_slave;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [4:0] tap_addr = '0;
  logic       sdo, sdo_oe;
  logic [7:0] tap_data;

  int   vectors = 0;
  int   errors = 0;
  bit   done = 0;
  bit   read_window = 0;
  logic [7:0] ref_mem [32];

  always #5 clk = ~clk;

  ser_reg_slave i_ser_reg_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .tap_addr(tap_addr), .tap_data(tap_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every clock: enable may only be high inside the data byte of a read frame
  always @(negedge clk) begin
    if (!rst && !done && !read_window)
      chk("R7 oe outside read data", {31'd0, sdo_oe}, 32'd0);
  end

  task automatic frame(input logic rw, input logic [4:0] a, input logic [1:0] junk,
                       input logic [7:0] d, input int nbits);
    logic b;
    @(negedge clk);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == 0)      b = rw;
      else if (i < 6)  b = a[i-1];
      else if (i < 8)  b = junk[i-6];
      else             b = d[i-8];
      sdi = b;
      tick(HALF);
      if (i < 8)
        chk("R7 oe in command byte", {31'd0, sdo_oe}, 32'd0);
      else if (rw) begin
        chk("R5 oe in read data", {31'd0, sdo_oe}, 32'd1);
        chk("R5 read bit", {31'd0, sdo}, {31'd0, ref_mem[a][i-8]});
      end
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
      if (i == 7 && rw) read_window = 1;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(6);
    if (read_window)
      chk("R8 oe dropped after select", {31'd0, sdo_oe}, 32'd0);
    read_window = 0;
    if (!rw && nbits == 16) ref_mem[a] = d;
  endtask

  task automatic tap_chk(input logic [4:0] a, input string req);
    tap_addr = a;
    tick(3);
    chk(req, {24'd0, tap_data}, {24'd0, ref_mem[a]});
  endtask

  initial begin
    for (int k = 0; k < 32; k++) ref_mem[k] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(2);
    chk("R10 oe after reset", {31'd0, sdo_oe}, 32'd0);
    for (int k = 0; k < 32; k++) tap_chk(5'(k), "R10 reset value");

    frame(1'b0, 5'd5, 2'b00, 8'hA5, 16);
    tap_chk(5'd5, "R1 write stored");
    frame(1'b0, 5'd0, 2'b00, 8'h3C, 16);
    tap_chk(5'd0, "R2 write direction");
    frame(1'b0, 5'd31, 2'b00, 8'h81, 16);
    tap_chk(5'd31, "R3 top address");
    tap_chk(5'd30, "R3 neighbour untouched");
    frame(1'b0, 5'd18, 2'b11, 8'h5E, 16);
    tap_chk(5'd18, "R4 ignored bits on write");
    tap_chk(5'd19, "R4 no alias");

    frame(1'b1, 5'd5, 2'b00, 8'h00, 16);
    frame(1'b1, 5'd31, 2'b01, 8'h00, 16);
    frame(1'b1, 5'd18, 2'b10, 8'h00, 16);
    frame(1'b1, 5'd0, 2'b00, 8'hFF, 16);
    tap_chk(5'd0, "R6 read leaves register");
    tap_chk(5'd5, "R2 read did not write");

    frame(1'b0, 5'd5, 2'b00, 8'h00, 15);
    tap_chk(5'd5, "R9 short write");
    frame(1'b0, 5'd18, 2'b00, 8'hFF, 4);
    tap_chk(5'd18, "R9 very short write");

    frame(1'b1, 5'd31, 2'b00, 8'h00, 11);
    frame(1'b1, 5'd0, 2'b00, 8'h00, 16);
    frame(1'b0, 5'd7, 2'b00, 8'hC3, 16);
    tap_chk(5'd7, "R8 frame after abort");

    tap_addr = 5'd31;
    @(negedge clk);
    tap_addr = 5'd5;
    tick(2);
    chk("R11 tap latency", {24'd0, tap_data}, {24'd0, ref_mem[5]});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule